// File: doc/BRIEF.md
# Three-Channel Averaging ADC Poller

This block is an SPI master that polls a three-channel 12-bit converter without pause. It visits the channels in a fixed round (0, then 1, then 2) and keeps a running 24-bit sum for each channel. It also keeps a 9-bit count of the completed rounds. A host reads the sums and the count together and divides to get averages. The SPI clock runs at half the block clock, so a 4.17 MHz input gives about 2.08 MHz on SCLK. That rate stays within the converter's limit at a 2.7 V supply.

Each conversion is one 24-bit frame with chip select low. The request goes out on MOSI and the 12 result bits come back on MISO, most significant bit first. The samples of a round are held in staging registers. When the round's last frame completes, all three sums and the count change in a single cycle, so a reader never sees a mix of two rounds.

A clear input empties the sums and the count and halts the bus. When clear is released, polling starts again at channel 0 with a fresh round.

Top module: `adc_poll_accum`

## Requirements
- R1: While chip select is low and was low in the previous cycle, SCLK toggles every clock cycle, so its period is two clock cycles. SCLK is low whenever chip select is high, and it is low in the cycle where chip select falls.
- R2: Each frame has exactly 24 SCLK rising edges while chip select is low. Between frames, chip select stays high for at least two clock cycles.
- R3: MOSI is 1 during frame bits 5 (start) and 6 (single-ended). During bits 7 and 8 it carries the 2-bit channel number, MSB first. It is 0 at every other bit and while chip select is high. The polled channel cycles 0, 1, 2, 0, and so on.
- R4: The sample is read from MISO at frame bits 12 to 23, MSB first. Each bit is taken on the clock edge that ends its SCLK-high phase.
- R5: `sums_o` holds three 24-bit sums packed as channel 2 in bits 71:48, channel 0 in bits 47:24, and channel 1 in bits 23:0.
- R6: The sums and the count change together in one cycle, only when a round of three frames completes. At all other times they hold their values.
- R7: The count rises by exactly one per completed round and stops at 511. Once it reaches 511, the sums also stop changing.
- R8: One cycle after `acc_clr_i` is seen high, the sums and the count are zero and chip select is high, and they stay that way while clear is held. After release, the first frame addresses channel 0, and the first round adds into empty sums.
- R9: While `rst_ni` is low, chip select is high, SCLK and MOSI are low, and the sums and the count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; SCLK is derived from it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_clr_i | input | 1 | Clears accumulation and halts polling while high |
| miso_i | input | 1 | Serial data from converter |
| sclk_o | output | 1 | SPI clock, half the block clock |
| cs_n_o | output | 1 | Converter select, active low |
| mosi_o | output | 1 | Serial request to converter |
| sums_o | output | 72 | Packed channel sums {ch2, ch0, ch1} |
| count_o | output | 9 | Completed rounds, saturating |

## Verification
The checker watches the bus timing on every cycle: the SCLK toggling, the SCLK idle level, and the minimum chip-select gap. It also checks every cycle that the sums move only when the count moves, that the count only steps by one or returns to zero, and that clear takes effect within one cycle.

Other behaviours need a converter model and known data, so only the bench scenarios can show them:
- the request bit pattern and the channel order;
- the MISO bit positions;
- the {ch2, ch0, ch1} packing;
- the exact sum values;
- saturation at 511 with frozen sums;
- a restart at channel 0 after clear.

// File: rtl/adc_poll_pkg.sv
package adc_poll_pkg;
    // channel count and address width are fixed by the frame format
    localparam int CH_N   = 3;
    localparam int ADDR_W = 2;

    // output slot (from LSB) of each channel: packing is {ch2, ch0, ch1}
    function automatic int chan_slot(input int ch);
        case (ch)
            0:       return 1;
            1:       return 0;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
    import adc_poll_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int FRAME_BITS = 24,
    parameter int START_POS  = 5,
    parameter int GAP_CYC    = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                clr_i,
    input  logic [ADDR_W-1:0]   ch_i,
    input  logic                miso_i,
    output logic                sclk_o,
    output logic                cs_n_o,
    output logic                mosi_o,
    output logic                smp_vld_o,
    output logic [SAMPLE_W-1:0] smp_o
);
    localparam int BIT_W    = $clog2(FRAME_BITS);
    localparam int GAP_W    = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam int DATA_LO  = FRAME_BITS - SAMPLE_W;
    localparam int ADDR_POS = START_POS + 2;

    typedef struct packed {
        logic                xfer;
        logic                ph;
        logic [BIT_W-1:0]    bitn;
        logic [GAP_W-1:0]    gap;
        logic [SAMPLE_W-1:0] sh;
        logic                vld;
    } eng_t;

    eng_t eng_d, eng_q;
    logic mosi_d;

    always_comb begin
        eng_d     = eng_q;
        eng_d.vld = 1'b0;
        if (clr_i) begin
            eng_d.xfer = 1'b0;
            eng_d.ph   = 1'b0;
            eng_d.bitn = '0;
            eng_d.gap  = '0;
        end else if (!eng_q.xfer) begin
            if (eng_q.gap == GAP_W'(GAP_CYC - 1)) begin
                eng_d.xfer = 1'b1;
                eng_d.gap  = '0;
                eng_d.bitn = '0;
                eng_d.ph   = 1'b0;
            end else begin
                eng_d.gap = eng_q.gap + GAP_W'(1);
            end
        end else if (!eng_q.ph) begin
            eng_d.ph = 1'b1;
        end else begin
            eng_d.ph = 1'b0;
            if (eng_q.bitn >= BIT_W'(DATA_LO))
                eng_d.sh = {eng_q.sh[SAMPLE_W-2:0], miso_i};
            if (eng_q.bitn == BIT_W'(FRAME_BITS - 1)) begin
                eng_d.xfer = 1'b0;
                eng_d.bitn = '0;
                eng_d.vld  = 1'b1;
            end else begin
                eng_d.bitn = eng_q.bitn + BIT_W'(1);
            end
        end

        // request pattern decoded from the current bit position
        mosi_d = 1'b0;
        if (eng_q.xfer) begin
            if (eng_q.bitn == BIT_W'(START_POS) || eng_q.bitn == BIT_W'(START_POS + 1))
                mosi_d = 1'b1;
            for (int j = 0; j < ADDR_W; j++)
                if (eng_q.bitn == BIT_W'(ADDR_POS + j))
                    mosi_d = ch_i[ADDR_W-1-j];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) eng_q <= '0;
        else         eng_q <= eng_d;
    end

    assign sclk_o    = eng_q.xfer & eng_q.ph;
    assign cs_n_o    = ~eng_q.xfer;
    assign mosi_o    = mosi_d;
    assign smp_vld_o = eng_q.vld;
    assign smp_o     = eng_q.sh;
endmodule

// File: rtl/adc_round_accum.sv
module adc_round_accum
    import adc_poll_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int SUM_W    = 24,
    parameter int CNT_W    = 9
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clr_i,
    input  logic                  vld_i,
    input  logic [SAMPLE_W-1:0]   smp_i,
    output logic [ADDR_W-1:0]     ch_o,
    output logic [CH_N*SUM_W-1:0] sum_o,
    output logic [CNT_W-1:0]      cnt_o
);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [ADDR_W-1:0] CH_LAST = ADDR_W'(CH_N - 1);

    typedef struct packed {
        logic [ADDR_W-1:0]               ch;
        logic [CH_N-2:0][SAMPLE_W-1:0]   stage;
        logic [CH_N-1:0][SUM_W-1:0]      sum;
        logic [CNT_W-1:0]                cnt;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            acc_d = '0;
        end else if (vld_i) begin
            if (acc_q.ch == CH_LAST) begin
                acc_d.ch = '0;
                if (acc_q.cnt != CNT_MAX) begin
                    for (int i = 0; i < CH_N - 1; i++)
                        acc_d.sum[i] = acc_q.sum[i] + SUM_W'(acc_q.stage[i]);
                    acc_d.sum[CH_N-1] = acc_q.sum[CH_N-1] + SUM_W'(smp_i);
                    acc_d.cnt = acc_q.cnt + CNT_W'(1);
                end
            end else begin
                for (int i = 0; i < CH_N - 1; i++)
                    if (acc_q.ch == ADDR_W'(i))
                        acc_d.stage[i] = smp_i;
                acc_d.ch = acc_q.ch + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) acc_q <= '0;
        else         acc_q <= acc_d;
    end

    assign ch_o  = acc_q.ch;
    assign sum_o = acc_q.sum;
    assign cnt_o = acc_q.cnt;
endmodule

// File: rtl/adc_poll_accum.sv
module adc_poll_accum
    import adc_poll_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int SUM_W      = 24,
    parameter int CNT_W      = 9,
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  acc_clr_i,
    input  logic                  miso_i,
    output logic                  sclk_o,
    output logic                  cs_n_o,
    output logic                  mosi_o,
    output logic [CH_N*SUM_W-1:0] sums_o,
    output logic [CNT_W-1:0]      count_o
);
    logic                  smp_vld;
    logic [SAMPLE_W-1:0]   smp;
    logic [ADDR_W-1:0]     ch;
    logic [CH_N*SUM_W-1:0] sum_by_ch;

    adc_spi_frame #(
        .SAMPLE_W  (SAMPLE_W),
        .FRAME_BITS(FRAME_BITS),
        .START_POS (5),
        .GAP_CYC   (2)
    ) u_frame (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (acc_clr_i),
        .ch_i     (ch),
        .miso_i   (miso_i),
        .sclk_o   (sclk_o),
        .cs_n_o   (cs_n_o),
        .mosi_o   (mosi_o),
        .smp_vld_o(smp_vld),
        .smp_o    (smp)
    );

    adc_round_accum #(
        .SAMPLE_W(SAMPLE_W),
        .SUM_W   (SUM_W),
        .CNT_W   (CNT_W)
    ) u_accum (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (acc_clr_i),
        .vld_i (smp_vld),
        .smp_i (smp),
        .ch_o  (ch),
        .sum_o (sum_by_ch),
        .cnt_o (count_o)
    );

    // reorder channel sums into output slots
    for (genvar g = 0; g < CH_N; g++) begin : g_pack
        localparam int SLOT = chan_slot(g);
        assign sums_o[SLOT*SUM_W +: SUM_W] = sum_by_ch[g*SUM_W +: SUM_W];
    end
endmodule

// File: rtl/adc_poll_accum_chk.sv
module adc_poll_accum_chk #(
    parameter int SUM_W = 24,
    parameter int CNT_W = 9
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               acc_clr_i,
    input logic               sclk_o,
    input logic               cs_n_o,
    input logic               mosi_o,
    input logic [3*SUM_W-1:0] sums_o,
    input logic [CNT_W-1:0]   count_o
);
    // R1
    sclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_n_o && !$past(cs_n_o)) |-> (sclk_o != $past(sclk_o)));
    // R1
    sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_n_o || $fell(cs_n_o)) |-> !sclk_o);
    // R2
    cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cs_n_o) |=> cs_n_o);
    // R3
    mosi_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n_o |-> !mosi_o);
    // R6
    sums_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(count_o) |-> $stable(sums_o));
    // R7
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o != $past(count_o)) |->
            ((count_o == $past(count_o) + CNT_W'(1)) || (count_o == '0)));
    // R8
    clear_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_clr_i |=> (cs_n_o && count_o == '0 && sums_o == '0));
endmodule

bind adc_poll_accum adc_poll_accum_chk #(.SUM_W(SUM_W), .CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_clr_i(acc_clr_i),
    .sclk_o   (sclk_o),
    .cs_n_o   (cs_n_o),
    .mosi_o   (mosi_o),
    .sums_o   (sums_o),
    .count_o  (count_o)
);

// File: tb/tb_adc_poll_accum.sv
module tb_adc_poll_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        miso = 1'b0;
    logic        sclk, cs_n, mosi;
    logic [71:0] sums;
    logic [8:0]  count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    adc_poll_accum dut (
        .clk_i(clk), .rst_ni(rst_n), .acc_clr_i(clr), .miso_i(miso),
        .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi),
        .sums_o(sums), .count_o(count)
    );

    task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model queues and scoreboard
    logic [11:0] smp_q0 [$];
    logic [11:0] smp_q1 [$];
    logic [11:0] smp_q2 [$];
    int          exp_cnt_q [$];
    logic [71:0] exp_sum_q [$];
    int          m_cnt = 0;
    logic [23:0] m_sum [3];
    int          exp_ch = 0;

    function automatic logic [71:0] pack3(input logic [23:0] s0, input logic [23:0] s1, input logic [23:0] s2);
        return {s2, s0, s1}; // R5 packing
    endfunction

    task automatic push_round(input logic [11:0] a, input logic [11:0] b, input logic [11:0] c, input bit expect_it);
        smp_q0.push_back(a); smp_q1.push_back(b); smp_q2.push_back(c);
        if (expect_it && m_cnt < 511) begin
            m_sum[0] += 24'(a); m_sum[1] += 24'(b); m_sum[2] += 24'(c);
            m_cnt++;
            exp_cnt_q.push_back(m_cnt);
            exp_sum_q.push_back(pack3(m_sum[0], m_sum[1], m_sum[2]));
        end
    endtask

    task automatic model_clear();
        m_cnt = 0; m_sum[0] = '0; m_sum[1] = '0; m_sum[2] = '0;
        exp_ch = 0;
    endtask

    // converter model: samples MOSI on SCLK rise, presents MISO bit for that position
    int          fr_cnt = 0;
    logic [23:0] fr_bits = '0;
    logic [11:0] fr_data = '0;
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            if (fr_cnt > 0 && !clr)
                chk(fr_cnt == 24, "R2 frame length", 72'(fr_cnt), 72'd24);
            fr_cnt = 0;
            miso = 1'b0;
        end else begin
            fr_bits[fr_cnt] = mosi;
            fr_cnt++;
            if (fr_cnt == 9) begin
                // R3: bit5 start, bit6 single-ended, bits7..8 channel MSB first
                chk(fr_bits[5] && fr_bits[6] && fr_bits[4:0] == '0 &&
                    {fr_bits[7], fr_bits[8]} == 2'(exp_ch),
                    "R3 request/channel", 72'(fr_bits[8:0]), 72'(exp_ch));
                case ({fr_bits[7], fr_bits[8]})
                    2'd0: fr_data = (smp_q0.size() > 0) ? smp_q0.pop_front() : 12'd0;
                    2'd1: fr_data = (smp_q1.size() > 0) ? smp_q1.pop_front() : 12'd0;
                    default: fr_data = (smp_q2.size() > 0) ? smp_q2.pop_front() : 12'd0;
                endcase
                exp_ch = (exp_ch + 1) % 3;
            end
            // R4: data bits occupy frame positions 12..23, MSB first
            if (fr_cnt - 1 >= 12) miso = fr_data[23 - (fr_cnt - 1)];
            else                  miso = 1'b0;
        end
    end

    // monitor: compare each count change against the scoreboard
    logic [8:0] prev_cnt = '0;
    always @(negedge clk) begin
        if (rst_n && count != prev_cnt && count != 0 && exp_cnt_q.size() > 0) begin
            int          ec;
            logic [71:0] es;
            ec = exp_cnt_q.pop_front();
            es = exp_sum_q.pop_front();
            chk(count == 9'(ec), "R7 round count", 72'(count), 72'(ec));
            chk(sums == es, "R6 R5 sums at round end", sums, es);
        end
        prev_cnt = count;
    end

    task automatic wait_scoreboard();
        while (exp_cnt_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_clear();
        bit cs_ok;
        @(negedge clk) clr = 1'b1;
        @(negedge clk);
        chk(cs_n && count == 0 && sums == 0, "R8 clear takes effect", {sums[62:0], count}, 72'h0);
        cs_ok = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (!cs_n || sclk || count != 0) cs_ok = 1'b0;
        end
        chk(cs_ok, "R8 bus idle while clear held", 72'(cs_ok), 72'd1);
        model_clear();
    endtask

    initial begin
        m_sum[0] = '0; m_sum[1] = '0; m_sum[2] = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(cs_n && !sclk && !mosi, "R9 bus idle in reset", {69'd0, cs_n, sclk, mosi}, 72'h4);
        chk(sums == 0 && count == 0, "R9 outputs zero in reset", {sums[62:0], count}, 72'h0);

        // phase A: varied data, including extremes
        push_round(12'd100, 12'd200, 12'd300, 1'b1);
        push_round(12'hFFF, 12'h000, 12'hFFF, 1'b1);
        push_round(12'd1, 12'd2, 12'd3, 1'b1);
        push_round(12'hABC, 12'h555, 12'hAAA, 1'b1);
        @(negedge clk) rst_n = 1'b1;
        wait_scoreboard();

        // R8: clear, then a fresh round starting from channel 0
        do_clear();
        push_round(12'h00F, 12'hF00, 12'h0F0, 1'b1);
        push_round(12'h800, 12'h001, 12'h7FF, 1'b1);
        @(negedge clk) clr = 1'b0;
        wait_scoreboard();
        chk(sums == pack3(24'h80F, 24'hF01, 24'h8EF), "R5 R8 packed sums after restart",
            sums, pack3(24'h80F, 24'hF01, 24'h8EF));

        // R7: saturation at 511 with frozen sums
        do_clear();
        for (int k = 0; k < 511; k++) push_round(12'hFFF, 12'hFFF, 12'hFFF, 1'b1);
        for (int k = 0; k < 3; k++)   push_round(12'd7, 12'd7, 12'd7, 1'b0);
        @(negedge clk) clr = 1'b0;
        wait_scoreboard();
        while (smp_q2.size() != 0) @(negedge clk);
        repeat (400) @(negedge clk);
        chk(count == 9'd511, "R7 count saturates", 72'(count), 72'd511);
        chk(sums == pack3(24'd2092545, 24'd2092545, 24'd2092545), "R7 sums frozen at saturation",
            sums, pack3(24'd2092545, 24'd2092545, 24'd2092545));

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule